// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial target that owns a small bank of 8-bit configuration registers. It watches the clock and data lines of an SMBus/I2C-style bus, resynchronises both into the system clock domain, and sees bus conditions as edges: START and repeated START are SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a START the target takes in a 7-bit device address and a direction bit. When the address is its own, it acknowledges and serves the transfer. Every register is also driven on a parallel output bus, so the logic around the block sees its settings directly.

A host writes one register with a three-byte transfer: the address byte with direction 0, a register pointer, and the data byte. To read a register, the host first sets the pointer with a short write phase, then issues a repeated START, sends the address byte with direction 1, and clocks in one byte. Register 0x00 is a control register. Writing it with bit 0 set reloads every register with its default value. The data line is open-drain, so the block only produces an enable that pulls SDA low.

Top module: `cfgbus_target`

## Requirements
- R1: After hardware reset, register i holds its default: 0x00 for i = 0 and (0x40 + i) modulo 256 for every other implemented i. The defaults appear on `cfg_regs_o`, with register i in bits [8i+7:8i].
- R2: After a START, the target takes in 7 address bits MSB first and then a direction bit (0 = write, 1 = read). If the address equals `DEV_ADDR`, it pulls SDA low for the whole ninth clock. `sda_oe_o` changes only while SCL is low.
- R3: In a write, the target ACKs the address byte, the pointer byte and one data byte, all shifted MSB first. The addressed register then holds the data byte. A register changes only when a write to it completes.
- R4: In a combined read (address+write, pointer, repeated START, address+read), the target ACKs all three bytes and then drives the selected register MSB first. After the host's NACK and STOP, SDA is released (`sda_oe_o` = 0).
- R5: When the address byte does not match, the ACK slot stays high. The target drives nothing until the next START or STOP, and the register contents do not change.
- R6: Pointers at or above `NUM_REGS` are unimplemented. A data byte written to such a pointer gets no ACK and changes no register. A read of such a pointer returns 0x00.
- R7: A START or STOP in the middle of a byte ends the transfer and releases SDA without writing a partial byte. A pointer that was already ACKed stays in effect for a following read.
- R8: Writing register 0x00 with bit 0 set reloads every register with its R1 default. Register 0x00 itself then reads 0x00, so the command bit clears itself.
- R9: Writing register 0x00 with bit 0 clear stores the byte like any other register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads the defaults |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| cfg_regs_o | output | NUM_REGS*8 | Contents of every register, register i in bits [8i+7:8i] |

## Verification
The bench drives the bus as an open-drain host and targets the corners where a faulty design shows itself at the pins.

| Stimulus | What a faulty design would do |
|---|---|
| A byte of 0x81 read back | A reversed bit order returns 0x81 unchanged, so this value cannot catch it. It is used together with 0xA5; a design that reversed bits would read 0xA5 back as 0xA5 too, and an off-by-one shift would garble both. |
| A STOP after four data bits | A target that commits early leaves a corrupted register. |
| A repeated START in mid-byte | A target that loses its pointer reads the wrong register. |
| A write to pointer 0x20 | A design with no range check ACKs the byte and aliases it onto a real register. |
| 0x01 and then 0x02 written to register 0x00 | These separate the reload command from a plain store. A design that ignored bit 0, or that treated any write to register 0x00 as a reset, fails one of the two. |

// File: rtl/cfgbus_pkg.sv
// Package: shared state encodings and the default-value rule of the
// configuration register target. Assumes at most 256 registers.
package cfgbus_pkg;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE,    // bus free, nothing addressed
        ST_RX,      // shifting in a byte from the host
        ST_RXHOLD,  // full byte received, waiting for SCL low to answer
        ST_ACK,     // target holds SDA low for the ninth clock
        ST_TX,      // target shifting a register out
        ST_TXACK,   // host answers the read byte
        ST_IGNORE   // not addressed or done, wait for START or STOP
    } fsm_state_t;

    // Which byte of the transfer is in progress.
    typedef enum logic [2:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_READ,
        PH_DONE
    } phase_t;

    localparam logic [7:0] CTRL_PTR       = 8'h00;
    localparam int unsigned SOFT_RST_BIT  = 0;

    // Default value loaded by hardware reset and by the reload command.
    function automatic logic [7:0] default_value(input int unsigned idx);
        logic [7:0] v;
        v = 8'(idx);
        if (idx == 0) begin
            return 8'h00;
        end
        return 8'h40 + v;
    endfunction

endpackage

// File: rtl/cfgbus_line_sync.sv
// Line conditioner: resynchronises SCL and SDA into the clk domain and
// decodes rising/falling SCL as well as START and STOP conditions.
// Assumes the bus lines stay stable for several clk cycles per phase.
module cfgbus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains plus one history stage; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
            scl_prev <= scl_pipe[MSB];
            sda_prev <= sda_pipe[MSB];
        end
    end

    // Edge and bus-condition decode from the synchronised lines.
    always_comb begin
        scl_s     = scl_pipe[MSB];
        sda_s     = sda_pipe[MSB];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/cfgbus_reg_bank.sv
// Register bank: NUM_REGS 8-bit registers with computed defaults, one
// write port, one read port returning 0x00 outside the bank, and a
// reload-all command carried by a write to the control register.
module cfgbus_reg_bank
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_ptr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_ptr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    logic [7:0] regs [NUM_REGS];
    logic       reload;

    // Reload command: control register written with its command bit set.
    always_comb begin
        reload = wr_en && (wr_ptr == CTRL_PTR) && wr_data[SOFT_RST_BIT];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // One storage byte: reset or reload to default, else take writes.
        always_ff @(posedge clk) begin
            if (!rst_n || reload) begin
                regs[g] <= default_value(g);
            end else if (wr_en && (wr_ptr == 8'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    // Read mux; unimplemented pointers return zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_ptr == 8'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/cfgbus_proto_fsm.sv
// Protocol engine: byte shifting, address compare, ACK generation,
// single-byte register writes and single-byte combined reads.
// Assumes edge strobes from cfgbus_line_sync; a START or STOP anywhere
// restarts or ends the transfer and releases SDA.
module cfgbus_proto_fsm
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_ptr,
    output logic       wr_en,
    output logic [7:0] wr_ptr,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output fsm_state_t state
);
    localparam logic [8:0] REG_LIMIT = 9'(NUM_REGS);

    phase_t     phase;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [6:0] tx_sh;
    logic [7:0] ptr_q;
    logic       ptr_ok;

    // Pointer range check against the implemented bank.
    always_comb begin
        ptr_ok = ({1'b0, ptr_q} < REG_LIMIT);
        rd_ptr = ptr_q;
    end

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            bit_cnt <= 3'd0;
            rx_sh   <= 8'h00;
            tx_sh   <= 7'h00;
            ptr_q   <= 8'h00;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= 8'h00;
            wr_data <= 8'h00;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                phase   <= PH_ADDR;
                bit_cnt <= 3'd0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                phase   <= PH_ADDR;
                bit_cnt <= 3'd0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                state <= ST_RXHOLD;
                            end
                        end
                    end
                    ST_RXHOLD: begin
                        if (scl_fall) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                        phase  <= rx_sh[0] ? PH_READ : PH_PTR;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr_q  <= rx_sh;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    phase  <= PH_DATA;
                                end
                                PH_DATA: begin
                                    if (ptr_ok) begin
                                        wr_en   <= 1'b1;
                                        wr_ptr  <= ptr_q;
                                        wr_data <= rx_sh;
                                        sda_oe  <= 1'b1;
                                        state   <= ST_ACK;
                                        phase   <= PH_DONE;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                default: state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= 3'd0;
                            if (phase == PH_READ) begin
                                state  <= ST_TX;
                                tx_sh  <= rd_data[6:0];
                                sda_oe <= ~rd_data[7];
                            end else if (phase == PH_DONE) begin
                                state  <= ST_IGNORE;
                                sda_oe <= 1'b0;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TXACK;
                            end else begin
                                bit_cnt <= bit_cnt + 3'd1;
                                sda_oe  <= ~tx_sh[6];
                                tx_sh   <= {tx_sh[5:0], 1'b0};
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            state <= ST_IGNORE;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgbus_target.sv
// Top: serial configuration register target. Chains the line
// conditioner, the protocol engine and the register bank. Assumes clk
// oversamples SCL by at least eight cycles per bus phase.
module cfgbus_target
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_regs_o
);
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [7:0] rd_ptr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_ptr;
    logic [7:0] wr_data;
    fsm_state_t fsm_state;

    cfgbus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgbus_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_ptr    (rd_ptr),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o),
        .state     (fsm_state)
    );

    cfgbus_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .rd_ptr    (rd_ptr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs_o)
    );

endmodule

// File: rtl/cfgbus_target_chk.sv
// Checker: temporal properties of the configuration register target,
// attached to every cfgbus_target instance through bind.
module cfgbus_target_chk
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_s,
    input  logic                  start_det,
    input  logic                  sda_oe,
    input  fsm_state_t            state,
    input  logic                  wr_en,
    input  logic [7:0]            wr_ptr,
    input  logic [7:0]            wr_data,
    input  logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam logic [8:0] REG_LIMIT = 9'(NUM_REGS);

    logic [NUM_REGS*8-1:0] dflt;

    // Expected image of the bank after a reload.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            dflt[i*8 +: 8] = default_value(i);
        end
    end

    // R2: the data line enable only moves while SCL is low.
    assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R3: registers hold unless a write strobe reached the bank.
    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    // R5: while idle or ignoring the bus, SDA stays released.
    assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    // R6: no write strobe ever targets an unimplemented pointer.
    assert_unimpl_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_ptr} < REG_LIMIT));

    // R7: a START always releases SDA on the next cycle.
    assert_start_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R8: the reload command restores the full default image.
    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == CTRL_PTR && wr_data[SOFT_RST_BIT]) |=> (cfg_regs == dflt));

endmodule

bind cfgbus_target cfgbus_target_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .sda_oe    (sda_oe_o),
    .state     (fsm_state),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .cfg_regs  (cfg_regs_o)
);

// File: tb/cfgbus_target_tb_top.sv
// Scoreboard bench: host tasks drive an open-drain bus, push expected
// items, and record observed values; a monitor pops and compares them.
module cfgbus_target_tb_top;
    localparam logic [6:0] DEV  = 7'h2A;
    localparam int         NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe_o;
    logic [NREG*8-1:0] cfg_regs_o;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_oe_o;

    always #2 clk = ~clk;

    cfgbus_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe_o),
        .cfg_regs_o (cfg_regs_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string exp_tag[$];
    int    exp_val[$];
    int    act_val[$];
    logic [7:0] mdl [NREG];

    function automatic logic [7:0] bench_default(input int i);
        return (i == 0) ? 8'h00 : 8'(8'h40 + i);
    endfunction

    task automatic expect_item(input string tag, input int v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    task automatic observe(input int v);
        act_val.push_back(v);
    endtask

    // Monitor: compare observed items against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            while (act_val.size() > 0 && exp_val.size() > 0) begin
                automatic int    a = act_val.pop_front();
                automatic int    e = exp_val.pop_front();
                automatic string t = exp_tag.pop_front();
                n_checks++;
                if (a != e) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
                end
            end
        end
    end

    task automatic qwait();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; qwait();
        scl_drv = 1'b1; qwait(); qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        b = sda_line; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(1'b1);
    endtask

    task automatic reg_write(input logic [6:0] addr, input logic [7:0] ptr,
                             input logic [7:0] data, input string tag,
                             input int e0, input int e1, input int e2);
        logic a;
        bus_start();
        expect_item({tag, " addr ack"}, e0);
        send_byte({addr, 1'b0}, a); observe(int'(a));
        expect_item({tag, " ptr ack"}, e1);
        send_byte(ptr, a); observe(int'(a));
        expect_item({tag, " data ack"}, e2);
        send_byte(data, a); observe(int'(a));
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] ptr, input int exp_data, input string tag);
        logic       a;
        logic [7:0] d;
        bus_start();
        expect_item({tag, " addr-w ack"}, 0);
        send_byte({DEV, 1'b0}, a); observe(int'(a));
        expect_item({tag, " ptr ack"}, 0);
        send_byte(ptr, a); observe(int'(a));
        bus_start();
        expect_item({tag, " addr-r ack"}, 0);
        send_byte({DEV, 1'b1}, a); observe(int'(a));
        expect_item({tag, " data"}, exp_data);
        recv_byte(d); observe(int'(d));
        bus_stop();
        expect_item({tag, " SDA released"}, 0);
        observe(int'(sda_oe_o));
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) begin
            expect_item($sformatf("%s reg%0d", tag, i), int'(mdl[i]));
            observe(int'(cfg_regs_o[i*8 +: 8]));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver: the test sequence.
    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) mdl[i] = bench_default(i);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        qwait();

        // R1: defaults after reset; R2: SDA released at idle
        check_regs("R1 reset");
        expect_item("R2 idle SDA", 0); observe(int'(sda_oe_o));

        // R2 R3: plain write
        reg_write(DEV, 8'h03, 8'hA5, "R3 write", 0, 0, 0);
        mdl[3] = 8'hA5;
        check_regs("R3 after write");

        // R4: combined reads, MSB first
        reg_read(8'h03, 8'hA5, "R4 read reg3");
        reg_write(DEV, 8'h06, 8'h81, "R3 write6", 0, 0, 0);
        mdl[6] = 8'h81;
        reg_read(8'h06, 8'h81, "R4 read reg6");
        reg_read(8'h01, 8'h41, "R4 read default reg1");

        // R5: another device's address
        reg_write(7'h11, 8'h03, 8'h00, "R5 mismatch", 1, 1, 1);
        check_regs("R5 unchanged");

        // R6: unimplemented pointer
        reg_write(DEV, 8'h20, 8'h77, "R6 unimpl", 0, 0, 1);
        check_regs("R6 unchanged");
        reg_read(8'h20, 8'h00, "R6 read unimpl");

        // R7: STOP after four data bits
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        scl_drv = 1'b0;
        bus_stop();
        check_regs("R7 stop abort");
        expect_item("R7 SDA after abort", 0); observe(int'(sda_oe_o));

        // R7: repeated START mid-byte keeps the ACKed pointer
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h04, a);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        expect_item("R7 restart addr-r ack", 0);
        send_byte({DEV, 1'b1}, a); observe(int'(a));
        expect_item("R7 restart data", 8'h44);
        recv_byte(d); observe(int'(d));
        bus_stop();
        check_regs("R7 restart unchanged");

        // R9: plain store into register 0x00
        reg_write(DEV, 8'h00, 8'h02, "R9 ctrl store", 0, 0, 0);
        mdl[0] = 8'h02;
        check_regs("R9 ctrl stored");
        reg_read(8'h00, 8'h02, "R9 read ctrl");

        // R8: reload command
        reg_write(DEV, 8'h05, 8'h3C, "R8 pre-write", 0, 0, 0);
        mdl[5] = 8'h3C;
        reg_write(DEV, 8'h00, 8'h01, "R8 reload", 0, 0, 0);
        for (int i = 0; i < NREG; i++) mdl[i] = bench_default(i);
        check_regs("R8 defaults");
        reg_read(8'h00, 8'h00, "R8 ctrl self-clear");

        repeat (4) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        if (exp_val.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d unmatched expected 0", exp_val.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule